// File: doc/BRIEF.md
# Rotate, Mask and Shift Unit

This block is the bit-manipulation datapath of an execution stage. It rotates a 64-bit source left by a computed amount. It then selects result bits through a mask built from two edge positions. Bits outside the mask come from a fill value: zero, the sign of the operand, or a caller-supplied merge word.

One shared rotator and one mask path serve five operation classes. These are merge-under-mask, keep-low, keep-high, left shift and right shift. Each class works on either a full 64-bit operand or a 32-bit operand in the low word.

Right shifts rotate by the negated amount and then trim the mask from the top. An arithmetic right shift also reports whether a negative value lost any 1 bit. The result and carry are captured into output registers when the enable input is high, so the result appears one clock later.

Top module: `rmu_top`

## Requirements
- R1: After reset `res_o` and `cy_o` are zero. When `en_i` is high at a rising edge, the outputs show that cycle's operation after the edge. When `en_i` is low, the outputs hold their previous values.
- R2: Operation code 0 (merge) rotates `src_i` left by `amt_i[5:0]`. Result bits inside the mask take the rotated value and bits outside take `ins_i`. When `lo_i <= hi_i`, the mask is bits `lo_i` through `hi_i` inclusive, numbered from bit 0 at the LSB.
- R3: When `lo_i > hi_i`, the merge mask wraps around: it covers bits at or above `lo_i` together with bits at or below `hi_i`.
- R4: Operation code 1 (keep-low) returns the rotated value with bits above `hi_i` cleared. Operation code 2 (keep-high) returns it with bits below `lo_i` cleared.
- R5: With `w32_i` high, rotating operations (codes 0 to 2) rotate the low 32-bit word by `amt_i[4:0]`, and that rotated word appears in both halves before masking.
- R6: Operation code 3 shifts left by `amt_i`, filling with zeros. With `w32_i` high, only the low word is shifted and the high word of the result is zero. An amount at or above the operand width (64, or 32 with `w32_i`) gives zero.
- R7: Operation code 4 with `sgn_i` low is a logical right shift by `amt_i`. With `w32_i` high it works on the low word and zero-extends. An amount at or above the operand width gives zero.
- R8: Operation code 4 with `sgn_i` high is an arithmetic right shift. It fills with the sign bit: bit 63, or bit 31 with `w32_i` high, sign-extended to 64 bits. An amount at or above the operand width gives all sign bits.
- R9: `cy_o` is high only after an arithmetic right shift whose operand is negative and which shifted out at least one 1 bit. An amount at or above the width counts every operand bit as shifted out.
- R10: Operation codes 5, 6 and 7 give a zero result and a zero carry.
- R11: `sgn_i` has no effect on operation codes 0 to 3, and for them `cy_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Capture enable for the output registers |
| op_i | input | 3 | Operation code: 0 merge, 1 keep-low, 2 keep-high, 3 shift left, 4 shift right |
| w32_i | input | 1 | 32-bit operand mode |
| sgn_i | input | 1 | Arithmetic selection for right shifts |
| src_i | input | 64 | Source operand |
| ins_i | input | 64 | Merge word for operation code 0 |
| amt_i | input | 7 | Rotate or shift amount |
| lo_i | input | 6 | Low mask edge |
| hi_i | input | 6 | High mask edge |
| res_o | output | 64 | Registered result |
| cy_o | output | 1 | Registered carry of arithmetic right shift |

## Verification
An arithmetic right shift drives the sign fill and the carry from the same rotated value and the same mask in one cycle. The bench therefore sweeps every shift amount from 0 to 127, in both operand widths, over negative sources with and without low 1 bits. For each vector it compares the result and the carry together against a model built from plain language shifts. The merge class reaches the wrap-around mask and the merge fill in one cycle, so every pair of edges is applied against a rotated source and a distinct merge word.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  typedef enum logic [2:0] {
    RMU_MERGE  = 3'd0,
    RMU_KEEPLO = 3'd1,
    RMU_KEEPHI = 3'd2,
    RMU_SHL    = 3'd3,
    RMU_SHR    = 3'd4
  } rmu_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_MERGE = 2'd1,
    FILL_SIGN  = 2'd2
  } rmu_fill_e;
endpackage

// File: rtl/rmu_rot_stage.sv
// One 4:1 rotate-left stage; selects a rotation of 0..3 times STEP.
module rmu_rot_stage #(
  parameter int XLEN = 64,
  parameter int STEP = 1
) (
  input  logic [XLEN-1:0] d,
  input  logic [1:0]      sel,
  output logic [XLEN-1:0] q
);
  localparam int S1 = STEP % XLEN;
  localparam int S2 = (2 * STEP) % XLEN;
  localparam int S3 = (3 * STEP) % XLEN;

  function automatic logic [XLEN-1:0] rotl(input logic [XLEN-1:0] x, input int k);
    if (k == 0) return x;
    return (x << k) | (x >> (XLEN - k));
  endfunction

  always_comb begin
    unique case (sel)
      2'd0:    q = d;
      2'd1:    q = rotl(d, S1);
      2'd2:    q = rotl(d, S2);
      default: q = rotl(d, S3);
    endcase
  end
endmodule

// File: rtl/rmu_edge_mask.sv
// Edge mask: with UPWARD set, ones at bits >= pos; otherwise ones at bits <= pos.
module rmu_edge_mask #(
  parameter int XLEN   = 64,
  parameter bit UPWARD = 1'b1,
  localparam int AW    = $clog2(XLEN)
) (
  input  logic          en,
  input  logic [AW-1:0] pos,
  output logic [XLEN-1:0] m
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (UPWARD) begin : g_up
      assign m[i] = en && (AW'(i) >= pos);
    end else begin : g_dn
      assign m[i] = en && (AW'(i) <= pos);
    end
  end
endmodule

// File: rtl/rmu_ctrl.sv
// Turns the operation class and flags into rotate amount, mask edges and fill choice.
module rmu_ctrl
  import rmu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int AW   = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic [2:0]    op,
  input  logic          w32,
  input  logic          sgn,
  input  logic [AW:0]   amt,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] rot_amt,
  output logic          up_en,
  output logic [AW-1:0] up_pos,
  output logic          dn_en,
  output logic [AW-1:0] dn_pos,
  output logic          join_or,
  output rmu_fill_e     fill,
  output logic          cy_en
);
  logic          beyond;
  logic [AW-1:0] top_idx;
  logic [AW:0]   neg_amt;

  always_comb begin
    top_idx = w32 ? AW'(HALF - 1) : AW'(XLEN - 1);
    beyond  = w32 ? (amt >= (AW+1)'(HALF)) : (amt >= (AW+1)'(XLEN));
    neg_amt = '0 - amt;

    rot_amt = amt[AW-1:0];
    up_en   = 1'b0;
    up_pos  = '0;
    dn_en   = 1'b0;
    dn_pos  = '0;
    join_or = 1'b0;
    fill    = FILL_ZERO;
    cy_en   = 1'b0;

    case (op)
      RMU_MERGE: begin
        up_en   = 1'b1;
        up_pos  = lo;
        dn_en   = 1'b1;
        dn_pos  = hi;
        join_or = (lo > hi);
        fill    = FILL_MERGE;
      end
      RMU_KEEPLO: begin
        up_en  = 1'b1;
        dn_en  = 1'b1;
        dn_pos = hi;
      end
      RMU_KEEPHI: begin
        up_en  = 1'b1;
        up_pos = lo;
        dn_en  = 1'b1;
        dn_pos = AW'(XLEN - 1);
      end
      RMU_SHL: begin
        up_en  = !beyond;
        up_pos = amt[AW-1:0];
        dn_en  = 1'b1;
        dn_pos = top_idx;
      end
      RMU_SHR: begin
        rot_amt = neg_amt[AW-1:0];
        up_en   = 1'b1;
        dn_en   = !beyond;
        dn_pos  = top_idx - amt[AW-1:0];
        fill    = sgn ? FILL_SIGN : FILL_ZERO;
        cy_en   = sgn;
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/rmu_top.sv
module rmu_top
  import rmu_pkg::*;
#(
  parameter int XLEN  = 64,
  localparam int AW   = $clog2(XLEN),
  localparam int HALF = XLEN / 2,
  localparam int NSTG = (AW + 1) / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [2:0]      op_i,
  input  logic            w32_i,
  input  logic            sgn_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] ins_i,
  input  logic [AW:0]     amt_i,
  input  logic [AW-1:0]   lo_i,
  input  logic [AW-1:0]   hi_i,
  output logic [XLEN-1:0] res_o,
  output logic            cy_o
);
  logic [AW-1:0]     rot_amt;
  logic              up_en, dn_en, join_or, cy_en;
  logic [AW-1:0]     up_pos, dn_pos;
  rmu_fill_e         fill;

  rmu_ctrl #(.XLEN(XLEN)) u_ctrl (
    .op(op_i), .w32(w32_i), .sgn(sgn_i), .amt(amt_i), .lo(lo_i), .hi(hi_i),
    .rot_amt(rot_amt), .up_en(up_en), .up_pos(up_pos), .dn_en(dn_en),
    .dn_pos(dn_pos), .join_or(join_or), .fill(fill), .cy_en(cy_en)
  );

  // Operand preparation: a 32-bit word is replicated so its rotation shows in both halves.
  logic [XLEN-1:0]   rot_in;
  logic [2*NSTG-1:0] rot_sel;
  assign rot_in  = w32_i ? {src_i[HALF-1:0], src_i[HALF-1:0]} : src_i;
  assign rot_sel = (2*NSTG)'(rot_amt);

  logic [XLEN-1:0] stg [NSTG+1];
  assign stg[0] = rot_in;
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    rmu_rot_stage #(.XLEN(XLEN), .STEP(1 << (2 * g))) u_stage (
      .d(stg[g]), .sel(rot_sel[2*g+1:2*g]), .q(stg[g+1])
    );
  end

  logic [XLEN-1:0] rot_v, up_m, dn_m;
  assign rot_v = stg[NSTG];

  rmu_edge_mask #(.XLEN(XLEN), .UPWARD(1'b1)) u_mask_up (
    .en(up_en), .pos(up_pos), .m(up_m)
  );
  rmu_edge_mask #(.XLEN(XLEN), .UPWARD(1'b0)) u_mask_dn (
    .en(dn_en), .pos(dn_pos), .m(dn_m)
  );

  logic [XLEN-1:0] sel_m, fill_v, wid_m, res_d;
  logic            sign_b, cy_d;

  always_comb begin
    sel_m  = join_or ? (up_m | dn_m) : (up_m & dn_m);
    sign_b = w32_i ? src_i[HALF-1] : src_i[XLEN-1];
    wid_m  = w32_i ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
    unique case (fill)
      FILL_MERGE: fill_v = ins_i;
      FILL_SIGN:  fill_v = {XLEN{sign_b}};
      default:    fill_v = '0;
    endcase
    res_d = (rot_v & sel_m) | (fill_v & ~sel_m);
    cy_d  = cy_en && sign_b && (|(rot_v & ~sel_m & wid_m));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      cy_o  <= 1'b0;
    end else if (en_i) begin
      res_o <= res_d;
      cy_o  <= cy_d;
    end
  end
endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
  parameter int XLEN  = 64,
  localparam int AW   = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic [2:0]      op_i,
  input logic            w32_i,
  input logic            sgn_i,
  input logic [XLEN-1:0] src_i,
  input logic [AW:0]     amt_i,
  input logic [AW-1:0]   lo_i,
  input logic [AW-1:0]   hi_i,
  input logic [XLEN-1:0] res_o,
  input logic            cy_o
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> $stable(res_o) && $stable(cy_o));

  assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $past(op_i) == 3'd0 && !$past(w32_i) && $past(amt_i[AW-1:0]) == '0
      && $past(lo_i) == '0 && $past(hi_i) == AW'(XLEN - 1)
    |-> res_o == $past(src_i));

  assert_shl_beyond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $past(op_i) == 3'd3 && !$past(w32_i) && $past(amt_i) >= (AW+1)'(XLEN)
    |-> res_o == '0);

  assert_sra_beyond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $past(op_i) == 3'd4 && $past(sgn_i) && !$past(w32_i)
      && $past(amt_i) >= (AW+1)'(XLEN)
    |-> res_o == {XLEN{$past(src_i[XLEN-1])}});

  assert_carry_needs_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && cy_o
    |-> $past(op_i) == 3'd4 && $past(sgn_i)
        && ($past(w32_i) ? $past(src_i[HALF-1]) : $past(src_i[XLEN-1])));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $past(op_i) > 3'd4 |-> res_o == '0 && !cy_o);

  assert_no_carry_other_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) && $past(op_i) < 3'd4 |-> !cy_o);
endmodule

bind rmu_top rmu_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .w32_i(w32_i),
  .sgn_i(sgn_i), .src_i(src_i), .amt_i(amt_i), .lo_i(lo_i), .hi_i(hi_i),
  .res_o(res_o), .cy_o(cy_o)
);

// File: tb/sim_rmu_top.sv
`timescale 1ns/1ps
module sim_rmu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [2:0]  op_i;
  logic        w32_i, sgn_i;
  logic [63:0] src_i, ins_i;
  logic [6:0]  amt_i;
  logic [5:0]  lo_i, hi_i;
  logic [63:0] res_o;
  logic        cy_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [63:0] lcg = 64'h0123_4567_89ab_cdef;

  always #2.5 clk = ~clk;

  rmu_top u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .w32_i(w32_i),
    .sgn_i(sgn_i), .src_i(src_i), .ins_i(ins_i), .amt_i(amt_i),
    .lo_i(lo_i), .hi_i(hi_i), .res_o(res_o), .cy_o(cy_o)
  );

  function automatic logic [63:0] nxt();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg ^ (lcg >> 29);
  endfunction

  // Reference built from language shifts, independent of the datapath structure.
  function automatic logic [64:0] model(input logic [2:0] op, input logic w32, input logic sgn,
      input logic [63:0] src, input logic [63:0] ins, input logic [6:0] amt,
      input logic [5:0] lo, input logic [5:0] hi);
    logic [63:0] v, r, m, res;
    logic [31:0] w, s32;
    logic        cy;
    int          k;
    w = src[31:0];
    cy = 1'b0;
    res = '0;
    if (op <= 3'd2) begin
      v = w32 ? {w, w} : src;
      k = w32 ? int'(amt[4:0]) : int'(amt[5:0]);
      r = (k == 0) ? v : ((v << k) | (v >> (64 - k)));
      for (int i = 0; i < 64; i++) begin
        if (op == 3'd0) m[i] = (lo <= hi) ? (i >= lo && i <= hi) : (i >= lo || i <= hi);
        else if (op == 3'd1) m[i] = (i <= hi);
        else m[i] = (i >= lo);
      end
      res = (r & m) | ((op == 3'd0 ? ins : 64'd0) & ~m);
    end else if (op == 3'd3) begin
      if (w32) begin
        v = {32'd0, w} << amt;
        res = {32'd0, v[31:0]};
      end else res = src << amt;
    end else if (op == 3'd4) begin
      if (w32) begin
        if (sgn) begin
          s32 = $signed(w) >>> amt;
          res = {{32{s32[31]}}, s32};
          cy = w[31] && ((amt >= 7'd32) ? (w != 0) : ((w & ((32'd1 << amt) - 32'd1)) != 0));
        end else res = {32'd0, w >> amt};
      end else begin
        if (sgn) begin
          res = $signed(src) >>> amt;
          cy = src[63] && ((amt >= 7'd64) ? (src != 0) : ((src & ((64'd1 << amt) - 64'd1)) != 0));
        end else res = src >> amt;
      end
    end
    return {cy, res};
  endfunction

  task automatic check(input string tag, input logic [63:0] exp_r, input logic exp_c);
    n_vec++;
    if (res_o !== exp_r || cy_o !== exp_c) begin
      n_bad++;
      $display("FAIL %s: res=%h cy=%b expected res=%h cy=%b (op=%0d w32=%b sgn=%b amt=%0d lo=%0d hi=%0d)",
               tag, res_o, cy_o, exp_r, exp_c, op_i, w32_i, sgn_i, amt_i, lo_i, hi_i);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge capture, checks at the next falling edge.
  task automatic apply(input string tag, input logic [2:0] op, input logic w32, input logic sgn,
      input logic [63:0] src, input logic [63:0] ins, input logic [6:0] amt,
      input logic [5:0] lo, input logic [5:0] hi);
    logic [64:0] e;
    en_i = 1'b1; op_i = op; w32_i = w32; sgn_i = sgn;
    src_i = src; ins_i = ins; amt_i = amt; lo_i = lo; hi_i = hi;
    e = model(op, w32, sgn, src, ins, amt, lo, hi);
    @(posedge clk);
    @(negedge clk);
    check(tag, e[63:0], e[64]);
  endtask

  initial begin
    logic [63:0] srcs [4];
    logic [63:0] held_r;
    logic        held_c;
    rst_n = 1'b0; en_i = 1'b0; op_i = '0; w32_i = 1'b0; sgn_i = 1'b0;
    src_i = '0; ins_i = '0; amt_i = '0; lo_i = '0; hi_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 64'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: every pair of mask edges on the merge class
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        apply((a > b) ? "R3 wrap mask" : "R2 merge", 3'd0, 1'b0, 1'b0,
              64'hf0e1_d2c3_b4a5_9687, 64'h5a5a_3c3c_0ff0_a5a5, 7'(a + b), 6'(a), 6'(b));

    // R4 R5 R11: rotating classes, both widths, both signed settings
    for (int op = 0; op < 3; op++)
      for (int w = 0; w < 2; w++)
        for (int amt = 0; amt < 64; amt++)
          for (int s = 0; s < 2; s++)
            apply(w ? "R5 rotate 32-bit" : (s ? "R11 sign ignored" : "R4 keep class"),
                  3'(op), w[0], s[0], nxt(), nxt(), 7'(amt), 6'(amt * 5), 6'(amt * 3 + 7));

    // R6 R7 R8 R9: every shift amount, widths, signedness, negative and positive sources
    srcs[0] = 64'h8000_0000_8000_0000;
    srcs[1] = 64'hffff_ffff_ffff_ffff;
    srcs[2] = 64'h7654_3210_fedc_ba98;
    srcs[3] = 64'h8123_4560_0000_0000;
    for (int op = 3; op < 5; op++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int amt = 0; amt < 128; amt++)
            for (int j = 0; j < 5; j++)
              apply((op == 3) ? "R6 shift left" : (s ? "R8 R9 arithmetic shift" : "R7 logical shift"),
                    3'(op), w[0], s[0], (j < 4) ? srcs[j] : nxt(), nxt(), 7'(amt), 6'(amt), 6'(amt + 9));

    // R10: reserved codes
    for (int op = 5; op < 8; op++)
      for (int k = 0; k < 8; k++)
        apply("R10 reserved code", 3'(op), k[0], k[1], nxt(), nxt(), 7'(k * 13), 6'(k), 6'(63 - k));

    // R1: enable low holds the captured result
    apply("R1 capture", 3'd4, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'd0, 7'd1, 6'd0, 6'd0);
    held_r = res_o;
    held_c = cy_o;
    en_i = 1'b0; op_i = 3'd3; src_i = 64'h1234; amt_i = 7'd4;
    @(posedge clk);
    @(negedge clk);
    check("R1 hold", held_r, held_c);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule